// File: doc/BRIEF.md
# Nine-bit serial command transmitter

This block drives a display controller that takes 9-bit serial words. Each word is a data/command flag bit and then an 8-bit payload. A register write is a single command word followed by any number of parameter words. The host presents one byte per valid/ready handshake, together with a marker that says whether the byte is the command and a marker that flags the final byte of the write. The block shifts the bits out on a serial clock, data line and active-low select using clock-idle-low timing. Data changes on the falling edge and is sampled on the rising edge. The serial clock is the system clock divided by a parameter.

There are two modes. In native mode each word goes out as its own 9-bit frame. In packed mode, meant for links that can only move whole bytes, eight words are joined into a 72-bit group and sent as nine bytes. If a write ends partway through a group, the rest of the group is filled with data-flagged zero words, so a group is always nine bytes long.

Top module: `nbt_serial_tx`

## Requirements
- R1: After reset, select is high, the serial clock is low and the input is ready to accept a byte.
- R2: In native mode every accepted byte produces exactly 9 rising serial clock edges. The flag bit goes first (0 for the command byte, 1 for a parameter byte), then the payload from bit 7 down to bit 0.
- R3: The serial clock idles low. The data line only changes while the clock is low, so it is stable through every high phase.
- R4: Select stays low without a break from the first bit of a write to the last bit of its final byte. Every bit of the write is clocked inside that window.
- R5: Between two writes, select stays high for at least 2*HALF_DIV system clocks, which is one serial clock period.
- R6: In packed mode, each run of eight words goes out as 72 bits. The first word sits in the most significant position, and the whole group is sent MSB first.
- R7: In packed mode, a write whose word count is not a multiple of eight is padded up to the next multiple of eight with the word 9'h100 (flag 1, payload 0x00).
- R8: The serial clock is never high while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pack_en | input | 1 | 1 selects packed mode, 0 selects native mode; change only between writes |
| wr_valid | input | 1 | A byte is offered |
| wr_ready | output | 1 | The block accepts the offered byte in this cycle |
| wr_byte | input | 8 | Command or parameter byte |
| wr_is_cmd | input | 1 | 1 when the byte is the command (flag sent as 0) |
| wr_last | input | 1 | 1 on the final byte of a write |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data |
| spi_cs_n | output | 1 | Active-low select |

## Verification
The hardest case to reach is a packed write that ends partway through a group when the group is not its first one. In that case select has to stay low across a full 72-bit group, then the pad words have to be inserted, and only then may select rise. The stimulus reaches it with directed writes of 3, 8, 9 and 16 words, plus random word counts up to twelve with random idle cycles between handshakes. Every captured bit of every write is compared with a stream built in the bench from the flag, the payload and the padding rules.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
  localparam int WORD_W = 9;
  localparam logic [WORD_W-1:0] NOP_WORD = 9'h100;
  typedef enum logic [1:0] {ST_IDLE, ST_ACTIVE, ST_GAP} link_state_e;
endpackage

// File: rtl/nbt_framer.sv
module nbt_framer
  import nbt_pkg::*;
#(
  parameter int WORDS = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           pack_en,
  input  logic                           wr_valid,
  output logic                           wr_ready,
  input  logic [7:0]                     wr_byte,
  input  logic                           wr_is_cmd,
  input  logic                           wr_last,
  input  logic                           take,
  output logic                           frm_full,
  output logic [WORD_W*WORDS-1:0]        frm_data,
  output logic [$clog2(WORD_W*WORDS+1)-1:0] frm_bits,
  output logic                           frm_last
);
  localparam int FRAME_W = WORD_W * WORDS;
  localparam int BITS_W  = $clog2(FRAME_W + 1);
  localparam int CNT_W   = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(WORDS - 1);

  logic [FRAME_W-1:0] grp_q, grp_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BITS_W-1:0]  bits_q, bits_d;
  logic               full_q, full_d, pad_q, pad_d, last_q, last_d;
  logic [WORD_W-1:0]  word;
  logic               accept;

  assign word     = {~wr_is_cmd, wr_byte};
  assign wr_ready = !full_q && !pad_q;
  assign accept   = wr_valid && wr_ready;

  always_comb begin
    grp_d  = grp_q;
    cnt_d  = cnt_q;
    bits_d = bits_q;
    full_d = full_q;
    pad_d  = pad_q;
    last_d = last_q;
    if (take) full_d = 1'b0;
    if (accept) begin
      if (!pack_en) begin
        grp_d  = {word, {(FRAME_W-WORD_W){1'b0}}};
        bits_d = BITS_W'(WORD_W);
        full_d = 1'b1;
        last_d = wr_last;
      end else begin
        grp_d = {grp_q[FRAME_W-WORD_W-1:0], word};
        if (cnt_q == LAST_SLOT) begin
          cnt_d  = '0;
          full_d = 1'b1;
          bits_d = BITS_W'(FRAME_W);
          last_d = wr_last;
        end else begin
          cnt_d = cnt_q + 1'b1;
          pad_d = wr_last;
        end
      end
    end else if (pad_q) begin
      grp_d = {grp_q[FRAME_W-WORD_W-1:0], NOP_WORD};
      if (cnt_q == LAST_SLOT) begin
        cnt_d  = '0;
        pad_d  = 1'b0;
        full_d = 1'b1;
        bits_d = BITS_W'(FRAME_W);
        last_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q  <= '0;
      cnt_q  <= '0;
      bits_q <= '0;
      full_q <= 1'b0;
      pad_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      grp_q  <= grp_d;
      cnt_q  <= cnt_d;
      bits_q <= bits_d;
      full_q <= full_d;
      pad_q  <= pad_d;
      last_q <= last_d;
    end
  end

  assign frm_full = full_q;
  assign frm_data = grp_q;
  assign frm_bits = bits_q;
  assign frm_last = last_q;
endmodule

// File: rtl/nbt_shifter.sv
module nbt_shifter #(
  parameter int HALF_DIV = 2,
  parameter int FRAME_W  = 72,
  parameter int BITS_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_data,
  input  logic [BITS_W-1:0]  load_bits,
  output logic               busy,
  output logic               done,
  output logic               sclk,
  output logic               mosi
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(HALF_DIV - 1);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [BITS_W-1:0]  left_q, left_d;
  logic [DIV_W-1:0]   div_q, div_d;
  logic               sclk_q, sclk_d, busy_q, busy_d;
  logic               tick;

  assign tick = busy_q && (div_q == DIV_TOP);
  assign done = tick && sclk_q && (left_q == BITS_W'(1));

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    div_d  = div_q;
    sclk_d = sclk_q;
    busy_d = busy_q;
    if (load) begin
      sh_d   = load_data;
      left_d = load_bits;
      div_d  = '0;
      sclk_d = 1'b0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (tick) begin
        div_d  = '0;
        sclk_d = ~sclk_q;
        if (sclk_q) begin
          sh_d   = {sh_q[FRAME_W-2:0], 1'b0};
          left_d = left_q - 1'b1;
          if (left_q == BITS_W'(1)) busy_d = 1'b0;
        end
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      div_q  <= '0;
      sclk_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      div_q  <= div_d;
      sclk_q <= sclk_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign sclk = sclk_q;
  assign mosi = busy_q & sh_q[FRAME_W-1];
endmodule

// File: rtl/nbt_serial_tx.sv
module nbt_serial_tx
  import nbt_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int WORDS    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pack_en,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_byte,
  input  logic       wr_is_cmd,
  input  logic       wr_last,
  output logic       spi_sclk,
  output logic       spi_mosi,
  output logic       spi_cs_n
);
  localparam int FRAME_W = WORD_W * WORDS;
  localparam int BITS_W  = $clog2(FRAME_W + 1);
  localparam int GAP_LEN = 2 * HALF_DIV;
  localparam int GAP_W   = $clog2(GAP_LEN + 1);

  logic               frm_full, frm_last, sh_busy, sh_done, launch;
  logic [FRAME_W-1:0] frm_data;
  logic [BITS_W-1:0]  frm_bits;
  link_state_e        st_q, st_d;
  logic               cs_q, cs_d, cur_last_q, cur_last_d;
  logic [GAP_W-1:0]   gap_q, gap_d;

  nbt_framer #(.WORDS(WORDS)) u_framer (
    .clk(clk), .rst_n(rst_n), .pack_en(pack_en),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_byte(wr_byte),
    .wr_is_cmd(wr_is_cmd), .wr_last(wr_last), .take(launch),
    .frm_full(frm_full), .frm_data(frm_data), .frm_bits(frm_bits),
    .frm_last(frm_last)
  );

  nbt_shifter #(.HALF_DIV(HALF_DIV), .FRAME_W(FRAME_W), .BITS_W(BITS_W)) u_shifter (
    .clk(clk), .rst_n(rst_n), .load(launch), .load_data(frm_data),
    .load_bits(frm_bits), .busy(sh_busy), .done(sh_done),
    .sclk(spi_sclk), .mosi(spi_mosi)
  );

  assign launch = frm_full && !sh_busy && (st_q != ST_GAP);

  always_comb begin
    st_d       = st_q;
    cs_d       = cs_q;
    cur_last_d = cur_last_q;
    gap_d      = gap_q;
    if (launch) cur_last_d = frm_last;
    unique case (st_q)
      ST_IDLE: begin
        if (launch) begin
          st_d = ST_ACTIVE;
          cs_d = 1'b0;
        end
      end
      ST_ACTIVE: begin
        if (sh_done && cur_last_q) begin
          st_d  = ST_GAP;
          cs_d  = 1'b1;
          gap_d = '0;
        end
      end
      ST_GAP: begin
        gap_d = gap_q + 1'b1;
        if (gap_q == GAP_W'(GAP_LEN - 1)) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cs_q       <= 1'b1;
      cur_last_q <= 1'b0;
      gap_q      <= '0;
    end else begin
      st_q       <= st_d;
      cs_q       <= cs_d;
      cur_last_q <= cur_last_d;
      gap_q      <= gap_d;
    end
  end

  assign spi_cs_n = cs_q;
endmodule

// File: rtl/nbt_checker.sv
module nbt_checker #(
  parameter int HALF_DIV = 2
) (
  input logic clk,
  input logic rst_n,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic spi_cs_n
);
  localparam int GAP_LEN = 2 * HALF_DIV;
  localparam int HI_W    = $clog2(GAP_LEN + 1);

  logic [HI_W-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= HI_W'(GAP_LEN);
    else if (!spi_cs_n) hi_cnt <= '0;
    else if (hi_cnt != HI_W'(GAP_LEN)) hi_cnt <= hi_cnt + 1'b1;
  end

  AST_IDLE_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (spi_cs_n && !spi_sclk)); // R1
  AST_MOSI_HELD_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi)); // R3
  AST_SELECT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (hi_cnt >= HI_W'(GAP_LEN))); // R5
  AST_NO_CLOCK_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R8
endmodule

bind nbt_serial_tx nbt_checker #(.HALF_DIV(HALF_DIV)) u_nbt_checker (
  .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk),
  .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
);

// File: tb/nbt_serial_tx_test.sv
`timescale 1ns/1ps
module nbt_serial_tx_test;
  localparam int HALF_DIV = 2;
  localparam int MAXB = 8192;

  logic       clk, rst_n, pack_en, wr_valid, wr_is_cmd, wr_last;
  logic [7:0] wr_byte;
  logic       wr_ready, spi_sclk, spi_mosi, spi_cs_n;

  nbt_serial_tx #(.HALF_DIV(HALF_DIV), .WORDS(8)) uut (
    .clk(clk), .rst_n(rst_n), .pack_en(pack_en), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_byte(wr_byte), .wr_is_cmd(wr_is_cmd),
    .wr_last(wr_last), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int    n_chk, n_bad;
  bit    exp_bits [MAXB];
  bit    got_bits [MAXB];
  int    en, gn, ntx, tdone;
  int    txn_end [256];
  string txn_tag [256];
  logic [7:0] tx_bytes [32];
  bit    mon_en, finished;
  bit    r3_bad, r8_bad;
  int    hi_cycles;
  logic  prev_sclk, prev_mosi;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // expected stream: flag (0 command, 1 data) then payload MSB first
  task automatic push_word(input bit flag, input logic [7:0] b);
    exp_bits[en++] = flag;
    for (int k = 7; k >= 0; k--) exp_bits[en++] = b[k];
  endtask

  task automatic send_txn(input int n, input bit pk);
    for (int i = 0; i < n; i++) push_word(i != 0, tx_bytes[i]);
    if (pk) for (int i = 0; i < (8 - n % 8) % 8; i++) push_word(1'b1, 8'h00); // R7 pad
    ntx++;
    txn_end[ntx] = en;
    txn_tag[ntx] = !pk ? "R2" : ((n % 8) != 0 ? "R7" : "R6");
    @(negedge clk);
    pack_en = pk;
    for (int i = 0; i < n; i++) begin
      wr_valid  = 1'b1;
      wr_byte   = tx_bytes[i];
      wr_is_cmd = (i == 0);
      wr_last   = (i == n - 1);
      while (!wr_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
      if (($urandom % 4) == 0) repeat ($urandom % 20) @(negedge clk);
    end
  endtask

  // capture bits at each rising serial clock edge
  always @(posedge spi_sclk) if (mon_en) begin
    if (gn < MAXB) got_bits[gn] = spi_mosi;
    gn++;
  end

  always @(negedge clk) if (mon_en) begin
    if (spi_cs_n && spi_sclk) r8_bad = 1'b1;
    if (spi_sclk && prev_sclk && spi_mosi !== prev_mosi) r3_bad = 1'b1;
    prev_sclk = spi_sclk;
    prev_mosi = spi_mosi;
  end

  always @(posedge clk) if (mon_en) begin
    if (spi_cs_n) hi_cycles++;
  end

  always @(negedge spi_cs_n) if (mon_en) begin
    check(hi_cycles >= 2 * HALF_DIV, "R5 select gap", hi_cycles, 2 * HALF_DIV);
    hi_cycles = 0;
  end

  always @(posedge spi_cs_n) if (mon_en) begin
    int first_bad;
    tdone++;
    check(gn == txn_end[tdone], "R4 bits inside select", gn, txn_end[tdone]);
    first_bad = -1;
    for (int k = txn_end[tdone-1]; k < txn_end[tdone] && k < gn; k++)
      if (first_bad < 0 && got_bits[k] != exp_bits[k]) first_bad = k;
    if (first_bad >= 0)
      check(1'b0, txn_tag[tdone], int'(got_bits[first_bad]), int'(exp_bits[first_bad]));
    else
      check(1'b1, txn_tag[tdone], 0, 0);
    gn = txn_end[tdone];
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", tdone, ntx);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    n_chk = 0; n_bad = 0; en = 0; gn = 0; ntx = 0; tdone = 0;
    txn_end[0] = 0; mon_en = 0; finished = 0; r3_bad = 0; r8_bad = 0;
    hi_cycles = 1000; prev_sclk = 1'b0; prev_mosi = 1'b0;
    rst_n = 1'b0; pack_en = 1'b0; wr_valid = 1'b0;
    wr_byte = 8'h00; wr_is_cmd = 1'b0; wr_last = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(spi_cs_n == 1'b1, "R1 cs_n", int'(spi_cs_n), 1);
    check(spi_sclk == 1'b0, "R1 sclk", int'(spi_sclk), 0);
    check(wr_ready == 1'b1, "R1 ready", int'(wr_ready), 1);
    mon_en = 1'b1;

    // directed: command alone, native
    tx_bytes[0] = 8'h11; send_txn(1, 1'b0);
    // native command with three parameters
    tx_bytes[0] = 8'hC1; tx_bytes[1] = 8'hFF; tx_bytes[2] = 8'h83; tx_bytes[3] = 8'h40;
    send_txn(4, 1'b0);
    // native extremes of payload
    tx_bytes[0] = 8'hFF; tx_bytes[1] = 8'h00; send_txn(2, 1'b0);
    // packed: exactly one group, partial group, group plus one, two groups
    for (int i = 0; i < 16; i++) tx_bytes[i] = 8'(8'hA0 + i * 7);
    send_txn(8, 1'b1);
    send_txn(3, 1'b1);
    send_txn(9, 1'b1);
    send_txn(16, 1'b1);
    tx_bytes[0] = 8'h29; send_txn(1, 1'b1);
    // constrained random
    for (int t = 0; t < 30; t++) begin
      int n;
      n = 1 + int'($urandom % 12);
      for (int i = 0; i < n; i++) tx_bytes[i] = 8'($urandom);
      send_txn(n, 1'($urandom % 2));
    end
    while (tdone < ntx) @(negedge clk);
    repeat (10) @(negedge clk);
    check(!r3_bad, "R3 mosi stable while sclk high", int'(r3_bad), 0);
    check(!r8_bad, "R8 sclk low while deselected", int'(r8_bad), 0);
    check(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R4 idle after last write",
          int'({spi_cs_n, spi_sclk}), 2);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule